// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block runs in-band software flow control for a single serial channel. It sits between the receive deserializer and the receive FIFO. It looks at every received character and compares it with two programmable codes: a resume code (XON) and a pause code (XOFF). When a character matches, the block raises an interrupt pulse. It then either drops the character or passes it on to the FIFO, as the transparency input selects.

A two-bit mode input switches the automation on in two places. On the transmit side, received codes pause and resume the local transmitter. On the receive side, the receive FIFO fill level makes the block ask the transmitter to insert a pause code or a resume code. The host can also, in any mode, force the transmitter paused or resumed, or ask for either code to be sent.

Code insertion uses a request/acknowledge handshake. The transmitter takes a pending code in place of FIFO data at its next character boundary. The transmitter samples the enable output only at character boundaries, so a pause takes effect once the character in flight has completed.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: A received character that equals neither code is pushed to the receive FIFO unchanged, in the same cycle as its strobe.
- R2: A received character equal to XON or XOFF is pushed when `transp_i`=1 and dropped when `transp_i`=0. This holds in every mode.
- R3: `irq_o` is a one-cycle pulse in the cycle after a received character matches XON or XOFF. It never pulses for any other reason, including code insertions and host commands.
- R4: Mode encoding: 00 = host only, 01 = automatic transmit, 10 = automatic receive, 11 = both. In modes 01 and 11, a received XOFF drives `tx_en_o` low in the next cycle and a received XON drives it high. In modes 00 and 10, received codes leave `tx_en_o` unchanged.
- R5: In any mode, `host_tx_pause_i` makes `tx_en_o` 0 in the next cycle and `host_tx_resume_i` makes it 1. A host command overrides a received code in the same cycle.
- R6: In modes 10 and 11, when `rx_level_i` >= HI_LVL (12) and no XOFF is outstanding, an XOFF insertion is requested. After that XOFF is sent, no further XOFF is requested until an XON has been sent.
- R7: In modes 10 and 11, once an XOFF has been sent and `rx_level_i` <= LO_LVL (8), an XON insertion is requested.
- R8: In modes 00 and 01, the FIFO level never produces an insertion request.
- R9: In any mode, a pulse on `host_send_xon_i` or `host_send_xoff_i` requests insertion of that code. The request is visible in the next cycle.
- R10: `ins_req_o` stays high, with `ins_char_o` holding the pending code, until `ins_ack_i` is sampled high. The served code is cleared in the cycle after the acknowledge. When both codes are pending, XOFF is presented first.
- R11: After reset, `tx_en_o`=1, `ins_req_o`=0, `irq_o`=0, and no XOFF is counted as outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received-character strobe |
| rx_char_i | input | CHAR_W | Received character |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| mode_i | input | 2 | Flow-control mode (see R4) |
| transp_i | input | 1 | 1 = pass matched codes to the FIFO |
| xon_char_i | input | CHAR_W | Resume code |
| xoff_char_i | input | CHAR_W | Pause code |
| host_send_xon_i | input | 1 | Host request to insert XON |
| host_send_xoff_i | input | 1 | Host request to insert XOFF |
| host_tx_pause_i | input | 1 | Host force transmitter paused |
| host_tx_resume_i | input | 1 | Host force transmitter resumed |
| ins_ack_i | input | 1 | Transmitter accepted the inserted code |
| rx_push_o | output | 1 | Push strobe to the receive FIFO |
| rx_push_char_o | output | CHAR_W | Character to push |
| tx_en_o | output | 1 | Transmitter enable, sampled at character boundaries |
| ins_req_o | output | 1 | Code insertion request |
| ins_char_o | output | CHAR_W | Code to insert |
| irq_o | output | 1 | Recognition interrupt pulse |

## Verification
The assertions check these properties on every cycle:
- non-matching characters pass through and matched codes are dropped when transparency is off;
- every interrupt traces back to a matched character one cycle earlier;
- a host pause always takes hold;
- `tx_en_o` never moves in the non-transmit modes without a host command;
- an insertion request is never withdrawn before it is acknowledged.

Only the bench scenarios can show the threshold behaviour of the receive-side automation. This covers the single XOFF per high-water episode, the XON at the low mark and the silence of modes 00 and 01. They also show the XOFF-first ordering when both codes are pending and the precedence of host commands over received codes.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  typedef enum logic [1:0] {
    FC_HOST      = 2'b00,
    FC_AUTO_TX   = 2'b01,
    FC_AUTO_RX   = 2'b10,
    FC_AUTO_BOTH = 2'b11
  } fc_mode_e;

  function automatic logic auto_tx(fc_mode_e m);
    return (m == FC_AUTO_TX) || (m == FC_AUTO_BOTH);
  endfunction

  function automatic logic auto_rx(fc_mode_e m);
    return (m == FC_AUTO_RX) || (m == FC_AUTO_BOTH);
  endfunction
endpackage

// File: rtl/xfc_char_match.sv
module xfc_char_match #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_char_i,
  input  logic [CHAR_W-1:0] xon_char_i,
  input  logic [CHAR_W-1:0] xoff_char_i,
  input  logic              transp_i,
  output logic              hit_on_o,
  output logic              hit_off_o,
  output logic              push_o,
  output logic [CHAR_W-1:0] push_char_o,
  output logic              irq_o
);
  // pause wins if both codes are programmed equal
  assign hit_off_o   = rx_valid_i && (rx_char_i == xoff_char_i);
  assign hit_on_o    = rx_valid_i && (rx_char_i == xon_char_i) && !hit_off_o;
  assign push_o      = rx_valid_i && (transp_i || !(hit_on_o || hit_off_o));
  assign push_char_o = rx_char_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= hit_on_o || hit_off_o;
  end
endmodule

// File: rtl/xfc_tx_gate.sv
module xfc_tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_tx_i,
  input  logic hit_on_i,
  input  logic hit_off_i,
  input  logic host_pause_i,
  input  logic host_resume_i,
  output logic tx_en_o
);
  logic paused_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      paused_q <= 1'b0;
    else if (host_pause_i)            paused_q <= 1'b1;
    else if (host_resume_i)           paused_q <= 1'b0;
    else if (auto_tx_i && hit_off_i)  paused_q <= 1'b1;
    else if (auto_tx_i && hit_on_i)   paused_q <= 1'b0;
  end

  assign tx_en_o = !paused_q;
endmodule

// File: rtl/xfc_rx_watch.sv
module xfc_rx_watch #(
  parameter int LVL_W  = 5,
  parameter int HI_LVL = 12,
  parameter int LO_LVL = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_rx_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             host_xon_i,
  input  logic             host_xoff_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic             sel_off_o
);
  logic pend_on_q, pend_off_q, sent_off_q;
  logic trig_on, trig_off, take_on, take_off;

  assign trig_off = auto_rx_i && (int'(level_i) >= HI_LVL) && !sent_off_q && !pend_off_q;
  assign trig_on  = auto_rx_i && (int'(level_i) <= LO_LVL) && sent_off_q && !pend_on_q;
  assign take_off = ack_i && pend_off_q;
  assign take_on  = ack_i && pend_on_q && !pend_off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_on_q  <= 1'b0;
      pend_off_q <= 1'b0;
      sent_off_q <= 1'b0;
    end else begin
      pend_off_q <= (pend_off_q && !take_off) || trig_off || host_xoff_i;
      pend_on_q  <= (pend_on_q && !take_on) || trig_on || host_xon_i;
      if (take_off)     sent_off_q <= 1'b1;
      else if (take_on) sent_off_q <= 1'b0;
    end
  end

  assign req_o     = pend_on_q || pend_off_q;
  assign sel_off_o = pend_off_q;
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
  import xfc_pkg::*;
#(
  parameter int CHAR_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int HI_LVL     = 12,
  parameter int LO_LVL     = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_char_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [1:0]        mode_i,
  input  logic              transp_i,
  input  logic [CHAR_W-1:0] xon_char_i,
  input  logic [CHAR_W-1:0] xoff_char_i,
  input  logic              host_send_xon_i,
  input  logic              host_send_xoff_i,
  input  logic              host_tx_pause_i,
  input  logic              host_tx_resume_i,
  input  logic              ins_ack_i,
  output logic              rx_push_o,
  output logic [CHAR_W-1:0] rx_push_char_o,
  output logic              tx_en_o,
  output logic              ins_req_o,
  output logic [CHAR_W-1:0] ins_char_o,
  output logic              irq_o
);
  fc_mode_e mode;
  logic hit_on, hit_off, sel_off;

  assign mode = fc_mode_e'(mode_i);

  xfc_char_match #(.CHAR_W(CHAR_W)) u_match (
    .clk_i, .rst_ni, .rx_valid_i, .rx_char_i, .xon_char_i, .xoff_char_i, .transp_i,
    .hit_on_o(hit_on), .hit_off_o(hit_off),
    .push_o(rx_push_o), .push_char_o(rx_push_char_o), .irq_o
  );

  xfc_tx_gate u_gate (
    .clk_i, .rst_ni, .auto_tx_i(auto_tx(mode)),
    .hit_on_i(hit_on), .hit_off_i(hit_off),
    .host_pause_i(host_tx_pause_i), .host_resume_i(host_tx_resume_i),
    .tx_en_o
  );

  xfc_rx_watch #(.LVL_W(LVL_W), .HI_LVL(HI_LVL), .LO_LVL(LO_LVL)) u_watch (
    .clk_i, .rst_ni, .auto_rx_i(auto_rx(mode)), .level_i(rx_level_i),
    .host_xon_i(host_send_xon_i), .host_xoff_i(host_send_xoff_i),
    .ack_i(ins_ack_i), .req_o(ins_req_o), .sel_off_o(sel_off)
  );

  assign ins_char_o = sel_off ? xoff_char_i : xon_char_i;
endmodule

// File: rtl/xfc_chk.sv
module xfc_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic [CHAR_W-1:0] rx_char_i,
  input logic [1:0]        mode_i,
  input logic              transp_i,
  input logic [CHAR_W-1:0] xon_char_i,
  input logic [CHAR_W-1:0] xoff_char_i,
  input logic              host_tx_pause_i,
  input logic              host_tx_resume_i,
  input logic              ins_ack_i,
  input logic              rx_push_o,
  input logic [CHAR_W-1:0] rx_push_char_o,
  input logic              tx_en_o,
  input logic              ins_req_o,
  input logic              irq_o
);
  logic is_code;
  assign is_code = (rx_char_i == xon_char_i) || (rx_char_i == xoff_char_i);

  // R1
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !is_code |-> rx_push_o && (rx_push_char_o == rx_char_i));
  // R2
  strip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && is_code && !transp_i |-> !rx_push_o);
  // R3
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(rx_valid_i && is_code));
  // R4
  no_auto_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[0] && !host_tx_pause_i && !host_tx_resume_i |=> $stable(tx_en_o));
  // R5
  host_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_tx_pause_i |=> !tx_en_o);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_req_o && !ins_ack_i |=> ins_req_o);
endmodule

bind xonxoff_flow_ctrl xfc_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk_i, .rst_ni, .rx_valid_i, .rx_char_i, .mode_i, .transp_i, .xon_char_i,
  .xoff_char_i, .host_tx_pause_i, .host_tx_resume_i, .ins_ack_i, .rx_push_o,
  .rx_push_char_o, .tx_en_o, .ins_req_o, .irq_o
);

// File: tb/xonxoff_flow_ctrl_bench.sv
`timescale 1ns/1ps
module xonxoff_flow_ctrl_bench;
  localparam int CW = 8;
  localparam int LW = 5;
  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;

  logic clk = 0, rst_ni = 0;
  logic rx_valid = 0, transp = 0;
  logic [CW-1:0] rx_char = 0;
  logic [LW-1:0] level = 0;
  logic [1:0] mode = 0;
  logic h_xon = 0, h_xoff = 0, h_pause = 0, h_resume = 0, ack = 0;
  logic rx_push, tx_en, ins_req, irq;
  logic [CW-1:0] push_char, ins_char;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xonxoff_flow_ctrl u_xonxoff_flow_ctrl (
    .clk_i(clk), .rst_ni, .rx_valid_i(rx_valid), .rx_char_i(rx_char),
    .rx_level_i(level), .mode_i(mode), .transp_i(transp),
    .xon_char_i(XON), .xoff_char_i(XOFF),
    .host_send_xon_i(h_xon), .host_send_xoff_i(h_xoff),
    .host_tx_pause_i(h_pause), .host_tx_resume_i(h_resume),
    .ins_ack_i(ack), .rx_push_o(rx_push), .rx_push_char_o(push_char),
    .tx_en_o(tx_en), .ins_req_o(ins_req), .ins_char_o(ins_char), .irq_o(irq)
  );

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    rx_valid = 0; h_xon = 0; h_xoff = 0; h_pause = 0; h_resume = 0; ack = 0;
  endtask

  function automatic bit exp_push(logic [7:0] c, bit tr);
    return tr || !(c == XON || c == XOFF);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bit exp_en, exp_irq;
    logic [7:0] c;
    bit tr;
    #1;
    chk("R11 tx_en in reset", tx_en, 1);
    chk("R11 req in reset", ins_req, 0);
    chk("R11 irq in reset", irq, 0);
    step(); step(); rst_ni = 1; step();

    // receive-side automation
    mode = 2'b10; level = 11; step();
    chk("R6 below high mark", ins_req, 0);
    level = 12; step();
    chk("R6 xoff requested", ins_req, 1);
    chk("R6 xoff char", ins_char, XOFF);
    chk("R3 no irq on request", irq, 0);
    ack = 1; step(); ack = 0;
    chk("R10 cleared after ack", ins_req, 0);
    step(); step(); step();
    chk("R6 single xoff", ins_req, 0);
    level = 9; step();
    chk("R7 above low mark", ins_req, 0);
    level = 8; step();
    chk("R7 xon requested", ins_req, 1);
    chk("R7 xon char", ins_char, XON);
    ack = 1; step(); ack = 0;
    chk("R10 xon cleared", ins_req, 0);
    chk("R3 no irq on insertion", irq, 0);

    // no level automation in modes 00 / 01
    mode = 2'b00; level = 15; step(); step();
    chk("R8 mode 00 silent", ins_req, 0);
    mode = 2'b01; step(); step();
    chk("R8 mode 01 silent", ins_req, 0);
    level = 0; mode = 2'b00;

    // host insertion and ordering
    h_xon = 1; step(); h_xon = 0;
    chk("R9 host xon req", ins_req, 1);
    chk("R9 host xon char", ins_char, XON);
    step(); step(); step();
    chk("R10 held without ack", ins_req, 1);
    h_xoff = 1; step(); h_xoff = 0;
    chk("R10 xoff first", ins_char, XOFF);
    ack = 1; step(); ack = 0;
    chk("R10 xon still pending", ins_req, 1);
    chk("R10 xon after xoff", ins_char, XON);
    ack = 1; step(); ack = 0;
    chk("R10 all served", ins_req, 0);
    chk("R3 no irq on host send", irq, 0);

    // transmitter gating
    h_pause = 1; step(); h_pause = 0;
    chk("R5 host pause mode 00", tx_en, 0);
    chk("R3 no irq on host pause", irq, 0);
    rx_valid = 1; rx_char = XON; transp = 0; #1;
    chk("R2 xon stripped", rx_push, 0);
    step(); quiet();
    chk("R4 mode 00 ignores xon", tx_en, 0);
    chk("R3 irq on match", irq, 1);
    step();
    chk("R3 irq one cycle", irq, 0);
    h_resume = 1; step(); h_resume = 0;
    chk("R5 host resume", tx_en, 1);
    mode = 2'b01;
    rx_valid = 1; rx_char = XOFF; transp = 1; #1;
    chk("R2 xoff passed transparent", rx_push, 1);
    step(); quiet();
    chk("R4 auto pause", tx_en, 0);
    rx_valid = 1; rx_char = XON; h_pause = 1; step(); quiet();
    chk("R5 host beats rx xon", tx_en, 0);
    rx_valid = 1; rx_char = XON; step(); quiet();
    chk("R4 auto resume", tx_en, 1);
    rx_valid = 1; rx_char = XOFF; h_resume = 1; step(); quiet();
    chk("R5 host beats rx xoff", tx_en, 1);
    step();

    // random characters across modes
    void'($urandom(32'h5eed));
    exp_en = 1;
    for (int i = 0; i < 400; i++) begin
      mode = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0: c = XON;
        1: c = XOFF;
        default: c = 8'($urandom);
      endcase
      tr = 1'($urandom);
      rx_valid = 1'($urandom); rx_char = c; transp = tr; #1;
      chk("R1 push", rx_push, rx_valid && exp_push(c, tr));
      if (rx_valid) chk("R1 push char", push_char, c);
      exp_irq = rx_valid && (c == XON || c == XOFF);
      if (rx_valid && mode[0] && c == XOFF) exp_en = 0;
      else if (rx_valid && mode[0] && c == XON) exp_en = 1;
      step();
      chk("R3 irq random", irq, exp_irq);
      chk("R4 tx_en random", tx_en, exp_en);
    end
    quiet(); step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule